// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Decoder

This block is the control logic that sits behind the pins of an asynchronous DRAM device. It watches active-low row strobe, column strobe, write enable and output enable, a shared row/column address bus, and separate data-in, data-out and output-drive signals that model the bidirectional data pins. A fast internal clock samples every pin through a synchroniser chain. Edges are found by comparing the newest sample with the one before it. Decoded strobe edges become reads and writes of a small internal storage array.

The order of the strobe edges selects the cycle type. When the row strobe falls while the column strobe is high, the block opens the addressed row, and each later column strobe fall reads or writes one column of that row. When the row strobe falls while the column strobe is already low, the address bus is ignored. The block instead refreshes the row named by an internal counter and reports that row on a one-cycle strobe. Read data is held in the extended-data-out style, so it survives a column strobe release and hidden refresh cycles. A mode input turns on nibble sequencing, in which column strobes after the first step through the next columns of an aligned group of four.

Top module: `adram_ctl`

## Requirements
- R1: After reset, `dout_en` is 0, `dout` is 0 and `rfsh_stb` is 0. The first refresh reports row 0.
- R2: A row strobe fall with the column strobe high latches `addr` as the row. A later column strobe fall with `we_n` low stores `din` at column `addr` of that row, and `dout_en` stays 0 for that write.
- R3: A column strobe fall with `we_n` high, while a row is open, reads the selected cell. With `oe_n` low, `dout_en` is 1 and `dout` shows the stored value.
- R4: While `oe_n` is high, `dout_en` is 0 and `dout` is 0 even when read data is held. Lowering `oe_n` shows the held data.
- R5: A row strobe fall while the column strobe is already low ignores `addr` and opens no row. `rfsh_stb` pulses for exactly one clock, and `rfsh_row` carries the internal counter value. Stored data is unchanged.
- R6: The refresh counter steps by one on each refresh and wraps from N_ROWS-1 to 0. Over N_ROWS refreshes in a row, every row is reported exactly once.
- R7: With the column strobe held low after a read, raising and lowering the row strobe performs a refresh while `dout_en` and `dout` keep the earlier read data.
- R8: Held read data stays on `dout` after the column strobe rises while the row strobe is low. It is replaced by the next column strobe read. It is dropped when the row strobe rises with the column strobe high, or when the column strobe rises with the row strobe high.
- R9: With `nib_mode` high, the first column strobe of a row uses `addr`. Each later one ignores `addr` and selects the previous column with its low two bits incremented modulo 4, with the upper column bits kept.
- R10: A strobe edge that reaches the pins just after a rising clock edge is acted upon at the third rising edge after that point, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, taken at column strobe fall |
| oe_n | input | 1 | Output enable, active low |
| nib_mode | input | 1 | 1 selects nibble column sequencing |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data, 0 when not driven |
| dout_en | output | 1 | Data pins driven |
| rfsh_stb | output | 1 | One-cycle pulse per refresh |
| rfsh_row | output | ROW_W | Row refreshed, valid with rfsh_stb |

## Verification
Every pin change goes through two synchroniser stages and one decode register, so a strobe change made just after a rising edge affects `dout`, `dout_en` and `rfsh_stb` after the third rising edge. The bench drives pins at a falling edge, lets four rising edges pass and samples at the following falling edge. One scenario samples after the second and third edges to pin the latency exactly. Refresh pulses last one full clock, so a falling-edge monitor counts each one once and records its row for comparison with a counter kept in the bench.

// File: rtl/adram_pkg.sv
`timescale 1ns/1ps
package adram_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_RFSH  = 2'd3
   } acc_e;
endpackage

// File: rtl/adram_sync.sv
`timescale 1ns/1ps
module adram_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("adram_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("adram_sync: at least two stages are needed");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/adram_edge.sv
`timescale 1ns/1ps
module adram_edge #(
   parameter int           W    = 1,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic [W-1:0] fall,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= cur;
   end

   assign fall = prev_q & ~cur;
   assign rise = ~prev_q & cur;
endmodule

// File: rtl/adram_refcnt.sv
`timescale 1ns/1ps
module adram_refcnt #(
   parameter int ROWS = 8,
   parameter int RW   = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   output logic          stb,
   output logic [RW-1:0] row
);
   localparam bit POW2 = ((ROWS & (ROWS - 1)) == 0);

   if (ROWS < 2) begin : g_bad_rows
      $error("adram_refcnt: ROWS must be at least 2");
   end

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] cnt_nxt;

   if (POW2) begin : g_wrap_nat
      assign cnt_nxt = cnt_q + 1'b1;
   end else begin : g_wrap_cmp
      assign cnt_nxt = (cnt_q == RW'(ROWS - 1)) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         stb   <= 1'b0;
         row   <= '0;
      end else begin
         stb <= req;
         if (req) begin
            row   <= cnt_q;
            cnt_q <= cnt_nxt;
         end
      end
   end

   // R6: the row reported is the count held before the request
   a_r6_row_report: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (stb && row == $past(cnt_q)));
   // R6: every refresh moves the counter
   a_r6_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (cnt_q != $past(cnt_q)));
   // R6: counter stays inside the row range
   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q) < ROWS);
endmodule

// File: rtl/adram_array.sv
`timescale 1ns/1ps
module adram_array #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   parameter int DW   = 4,
   parameter int RW   = $clog2(ROWS),
   parameter int CW   = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = ROWS * COLS;
   localparam int IW    = $clog2(DEPTH);

   if (DEPTH > 4096) begin : g_bad_depth
      $error("adram_array: storage too large for this model");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [IW-1:0] idx;
   logic          in_range;

   assign in_range = (32'(row) < ROWS) && (32'(col) < COLS);
   assign idx      = IW'(row) * IW'(COLS) + IW'(col);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr && in_range) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = in_range ? mem[idx] : '0;
endmodule

// File: rtl/adram_ctl.sv
`timescale 1ns/1ps
module adram_ctl #(
   parameter int N_ROWS      = 8,
   parameter int N_COLS      = 8,
   parameter int DW          = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ROW_W       = $clog2(N_ROWS),
   parameter int COL_W       = $clog2(N_COLS),
   parameter int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              nib_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout,
   output logic              dout_en,
   output logic              rfsh_stb,
   output logic [ROW_W-1:0]  rfsh_row
);
   import adram_pkg::*;

   if (N_COLS % 4 != 0) begin : g_bad_cols
      $error("adram_ctl: N_COLS must be a multiple of 4 for nibble groups");
   end
   if (DW < 1) begin : g_bad_dw
      $error("adram_ctl: DW must be at least 1");
   end

   // ---------------- pin sampling ----------------
   logic [4:0]        ctl_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DW-1:0]     din_s;

   adram_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b01111)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({nib_mode, oe_n, we_n, cas_n, ras_n}), .q(ctl_s));
   adram_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_addr (
      .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));
   adram_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

   logic ras_s, cas_s, we_s, oe_s, nib_s;
   assign ras_s = ctl_s[0];
   assign cas_s = ctl_s[1];
   assign we_s  = ctl_s[2];
   assign oe_s  = ctl_s[3];
   assign nib_s = ctl_s[4];

   logic [1:0] st_fall, st_rise;
   adram_edge #(.W(2), .INIT(2'b11)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur({cas_s, ras_s}),
      .fall(st_fall), .rise(st_rise));

   logic ras_fall, cas_fall, ras_rise, cas_rise;
   assign ras_fall = st_fall[0];
   assign cas_fall = st_fall[1];
   assign ras_rise = st_rise[0];
   assign cas_rise = st_rise[1];

   // ---------------- cycle decode ----------------
   logic             row_open_q;
   logic             nib_armed_q;
   logic             rd_valid_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [DW-1:0]    dout_q;
   logic [COL_W-1:0] col_nib;
   logic [COL_W-1:0] col_sel;
   logic [DW-1:0]    rdata;
   acc_e             acc;

   always_comb begin
      acc = ACC_NONE;
      if (ras_fall && !cas_s && !cas_fall)
         acc = ACC_RFSH;
      else if (cas_fall && row_open_q && !ras_fall)
         acc = we_s ? ACC_READ : ACC_WRITE;
   end

   assign col_nib = {col_q[COL_W-1:2], col_q[1:0] + 2'd1};
   assign col_sel = (nib_s && nib_armed_q) ? col_nib : addr_s[COL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open_q  <= 1'b0;
         nib_armed_q <= 1'b0;
         rd_valid_q  <= 1'b0;
         row_q       <= '0;
         col_q       <= '0;
         dout_q      <= '0;
      end else begin
         if (ras_fall && acc != ACC_RFSH) begin
            row_open_q  <= 1'b1;
            row_q       <= addr_s[ROW_W-1:0];
            nib_armed_q <= 1'b0;
         end else if (ras_rise) begin
            row_open_q  <= 1'b0;
         end

         if (acc == ACC_READ || acc == ACC_WRITE) begin
            col_q       <= col_sel;
            nib_armed_q <= 1'b1;
         end

         if (acc == ACC_READ) begin
            rd_valid_q <= 1'b1;
            dout_q     <= rdata;
         end else if (acc == ACC_WRITE) begin
            rd_valid_q <= 1'b0;
         end else if ((ras_rise && cas_s) || (cas_rise && ras_s)) begin
            rd_valid_q <= 1'b0;
         end
      end
   end

   // ---------------- storage and refresh ----------------
   adram_array #(.ROWS(N_ROWS), .COLS(N_COLS), .DW(DW),
                 .RW(ROW_W), .CW(COL_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr(acc == ACC_WRITE),
      .row(row_q), .col(col_sel), .wdata(din_s), .rdata(rdata));

   adram_refcnt #(.ROWS(N_ROWS), .RW(ROW_W)) u_refcnt (
      .clk(clk), .rst_n(rst_n), .req(acc == ACC_RFSH),
      .stb(rfsh_stb), .row(rfsh_row));

   assign dout_en = rd_valid_q && !oe_s;
   assign dout    = dout_en ? dout_q : '0;

   // ---------------- checks ----------------
   // R8: held data only changes at a column strobe fall
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_fall |=> $stable(dout_q));
   // R5: refresh opens no row
   a_r5_no_row: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_RFSH) |=> !row_open_q);
   // R5: refresh strobe is a single-cycle pulse
   a_r5_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_stb |=> !rfsh_stb);
   // R7: row strobe release under a low column strobe keeps read data
   a_r7_hidden_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_q && ras_rise && !cas_s) |=> rd_valid_q);
   // R2: a write leaves the data pins undriven
   a_r2_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_WRITE) |=> !dout_en);
   // R3: a read cycle leaves data held
   a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_READ) |=> rd_valid_q);
endmodule

// File: tb/adram_ctl_bench.sv
`timescale 1ns/1ps
module adram_ctl_bench;
   localparam int ROWS = 8;
   localparam int DW   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic       nib_mode = 1'b0;
   logic [2:0] addr = '0;
   logic [3:0] din = '0;
   logic [3:0] dout;
   logic       dout_en;
   logic       rfsh_stb;
   logic [2:0] rfsh_row;

   int n_chk = 0;
   int n_bad = 0;
   int stb_seen = 0;
   int last_row = -1;
   int exp_row = 0;

   adram_ctl u_adram_ctl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .nib_mode(nib_mode), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row));

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && rfsh_stb) begin
         stb_seen = stb_seen + 1;
         last_row = int'(rfsh_row);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic do_write(input int r, input int c, input int d);
      addr = 3'(r); ras_n = 1'b0; settle();
      addr = 3'(c); din = 4'(d); we_n = 1'b0; cas_n = 1'b0; settle();
      chk("R2 write leaves dout_en low", int'(dout_en), 0);
      cas_n = 1'b1; we_n = 1'b1; settle();
      ras_n = 1'b1; settle();
   endtask

   task automatic do_read(input int r, input int c, input int exp, input string req);
      addr = 3'(r); ras_n = 1'b0; settle();
      addr = 3'(c); cas_n = 1'b0; settle();
      chk({req, " dout_en"}, int'(dout_en), 1);
      chk({req, " dout"}, int'(dout), exp);
      cas_n = 1'b1; settle();
      ras_n = 1'b1; settle();
   endtask

   task automatic do_cbr(input int junk, input string req);
      int n0;
      n0 = stb_seen;
      cas_n = 1'b0; settle();
      addr = 3'(junk); ras_n = 1'b0; settle();
      chk({req, " one refresh pulse"}, stb_seen, n0 + 1);
      chk({req, " refresh row"}, last_row, exp_row);
      chk({req, " no output during refresh"}, int'(dout_en), 0);
      exp_row = (exp_row + 1) % ROWS;
      ras_n = 1'b1; settle();
      cas_n = 1'b1; settle();
   endtask

   task automatic t_reset();
      chk("R1 dout_en after reset", int'(dout_en), 0);
      chk("R1 dout after reset", int'(dout), 0);
      chk("R1 rfsh_stb after reset", int'(rfsh_stb), 0);
   endtask

   task automatic t_write_read();
      do_write(1, 2, 4'hA);
      do_write(5, 7, 4'h3);
      do_write(0, 0, 4'hF);
      do_write(1, 3, 4'h6);
      do_read(1, 2, 4'hA, "R3 read r1c2");
      do_read(5, 7, 4'h3, "R3 read r5c7");
      do_read(0, 0, 4'hF, "R3 read r0c0");
      do_read(2, 2, 4'h0, "R2 untouched cell");
   endtask

   task automatic t_oe();
      oe_n = 1'b1;
      addr = 3'd5; ras_n = 1'b0; settle();
      addr = 3'd7; cas_n = 1'b0; settle();
      chk("R4 dout_en with oe high", int'(dout_en), 0);
      chk("R4 dout with oe high", int'(dout), 0);
      oe_n = 1'b0; settle();
      chk("R4 dout_en after oe low", int'(dout_en), 1);
      chk("R4 dout after oe low", int'(dout), 3);
      cas_n = 1'b1; settle();
      ras_n = 1'b1; settle();
   endtask

   task automatic t_edo();
      addr = 3'd1; ras_n = 1'b0; settle();
      addr = 3'd2; cas_n = 1'b0; settle();
      chk("R8 first read", int'(dout), 4'hA);
      cas_n = 1'b1; settle();
      chk("R8 held after cas rise", int'(dout_en), 1);
      chk("R8 data after cas rise", int'(dout), 4'hA);
      addr = 3'd3; cas_n = 1'b0; settle();
      chk("R8 next column replaces", int'(dout), 4'h6);
      cas_n = 1'b1; settle();
      ras_n = 1'b1; settle();
      chk("R8 dropped at ras rise", int'(dout_en), 0);
   endtask

   task automatic t_cbr();
      do_cbr(5, "R5 first refresh");
      do_read(1, 2, 4'hA, "R5 data intact after refresh");
   endtask

   task automatic t_hidden();
      int n0;
      addr = 3'd5; ras_n = 1'b0; settle();
      addr = 3'd7; cas_n = 1'b0; settle();
      chk("R7 read before hidden", int'(dout), 3);
      ras_n = 1'b1; settle();
      chk("R7 valid after ras rise", int'(dout_en), 1);
      n0 = stb_seen;
      addr = 3'd6; ras_n = 1'b0; settle();
      chk("R7 hidden refresh pulse", stb_seen, n0 + 1);
      chk("R7 hidden refresh row", last_row, exp_row);
      exp_row = (exp_row + 1) % ROWS;
      chk("R7 dout_en during hidden", int'(dout_en), 1);
      chk("R7 dout during hidden", int'(dout), 3);
      ras_n = 1'b1; settle();
      chk("R7 still valid", int'(dout), 3);
      cas_n = 1'b1; settle();
      chk("R8 dropped at cas rise with ras high", int'(dout_en), 0);
   endtask

   task automatic t_wrap();
      int hits [ROWS];
      for (int i = 0; i < ROWS; i++) hits[i] = 0;
      for (int i = 0; i < ROWS; i++) begin
         do_cbr(i, "R6 sweep");
         if (last_row >= 0 && last_row < ROWS) hits[last_row]++;
      end
      for (int i = 0; i < ROWS; i++) chk("R6 each row once", hits[i], 1);
      do_cbr(7, "R6 after wrap");
   endtask

   task automatic t_nibble();
      do_write(3, 4, 4'h9);
      do_write(3, 5, 4'h8);
      do_write(3, 6, 4'h7);
      do_write(3, 7, 4'h1);
      nib_mode = 1'b1;
      addr = 3'd3; ras_n = 1'b0; settle();
      addr = 3'd6; cas_n = 1'b0; settle();
      chk("R9 first column from addr", int'(dout), 4'h7);
      cas_n = 1'b1; addr = 3'd0; settle();
      cas_n = 1'b0; settle();
      chk("R9 second column", int'(dout), 4'h1);
      cas_n = 1'b1; settle();
      cas_n = 1'b0; settle();
      chk("R9 wraps in group", int'(dout), 4'h9);
      cas_n = 1'b1; settle();
      cas_n = 1'b0; settle();
      chk("R9 fourth column", int'(dout), 4'h8);
      cas_n = 1'b1; settle();
      ras_n = 1'b1; nib_mode = 1'b0; settle();
   endtask

   task automatic t_latency();
      addr = 3'd0; ras_n = 1'b0; settle();
      addr = 3'd0; cas_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10 not yet after two edges", int'(dout_en), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R10 valid after third edge", int'(dout_en), 1);
      chk("R10 data", int'(dout), 4'hF);
      settle();
      cas_n = 1'b1; settle();
      ras_n = 1'b1; settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_write_read();
      t_oe();
      t_edo();
      t_cbr();
      t_hidden();
      t_wrap();
      t_nibble();
      t_latency();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end
endmodule